// File: doc/BRIEF.md
# Per-Channel Output-Enable Control Serializer

This block drives one serial control line that tells external pad drivers, channel by channel, whether eight interleaved backplane output streams should drive or float. A bit clock at 16.384 MHz steps through a 2048-period frame. The line always runs at that rate, whatever rate each served stream uses. Each control bit is taken from a small enable memory, addressed by a local stream index (0 to 7) and a channel number. Software-side logic loads that memory through a single-bit write port.

Control bits are sent ahead of the frame boundary. The eight streams take the eight consecutive periods of every group of eight, with local stream 0 first. When a stream runs slower than the line rate, each of its channels spans several groups, and its enable bit is resent in every one of them. A second instance with the same parameters serves the other eight streams of a 16-stream system.

Top module: `oe_ctrl_serializer`

## Requirements
- R1: While rst_ni is low, ctrl_o is 0. Reset clears every enable bit and selects the 2.048 Mb/s rate for every stream.
- R2: A cycle with frame_i high is period 0. Each later cycle is one period after the one before it, and period 2047 is followed by period 0.
- R3: Let the slot index be q = (period + 9) mod 2048. The bit in period p belongs to local stream q mod 8 and group q div 8. So stream 0 channel 0 is sent in period 2039 and stream 7 channel 0 in period 2046.
- R4: For a stream at rate code 3 (16.384 Mb/s, 256 channels), group g carries channel g, and each bit is sent once per frame.
- R5: For rate code 2 (8.192 Mb/s, 128 channels), group g carries channel g div 2, so each bit is sent twice (for example, stream 2 channel 1 in periods 9 and 17).
- R6: For rate code 1 (4.096 Mb/s, 64 channels), group g carries channel g div 4, so each bit is sent four times.
- R7: For rate code 0 (2.048 Mb/s, 32 channels), group g carries channel g div 8, so each bit is sent eight times, eight periods apart.
- R8: ctrl_o equals the stored enable bit of the addressed stream and channel, where 0 asks for high impedance. A write with wr_en_i high at a rising edge stores wr_bit_i at entry (wr_stream_i, wr_chan_i).
- R9: The 2-bit rate code of local stream k sits in rate_i[2k+1:2k]. It is sampled only at the rising edge that ends period 2038. A change at any other time has no effect on ctrl_o until that edge.
- R10: A write that lands at the edge ending period p does not affect the bit sent in period p+1. It does take effect from period p+2 on, including later repeats of the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16.384 MHz bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | High in the cycle that is period 0 |
| rate_i | input | 16 | Per-stream rate codes, 2 bits per local stream |
| wr_en_i | input | 1 | Enable-memory write strobe |
| wr_stream_i | input | 3 | Local stream index of the write |
| wr_chan_i | input | 8 | Channel index of the write |
| wr_bit_i | input | 1 | Enable value to store |
| ctrl_o | output | 1 | Serial per-channel output-enable line |

## Verification
Two things can meet in one cycle: a memory write, and the look-ahead read that fetches the next period's bit. The bench provokes this on purpose. For about 1400 consecutive cycles it writes the inverted value into exactly the entry being read in that cycle. The bench model then expects the old value in the next period and the new value in every later repeat of that channel. A mid-frame rate change is also placed where it meets the sampling point, and the bench checks that the old mapping holds until period 2039.

// File: rtl/oecs_pkg.sv
package oecs_pkg;
  localparam int RATE_W = 2;

  typedef enum logic [RATE_W-1:0] {
    RATE_2M  = 2'd0,
    RATE_4M  = 2'd1,
    RATE_8M  = 2'd2,
    RATE_16M = 2'd3
  } rate_e;

  // repeat factor is 2**(RATE_TOP - code)
  localparam logic [RATE_W-1:0] RATE_TOP = 2'd3;
endpackage

// File: rtl/oecs_slot_timer.sv
module oecs_slot_timer #(
  parameter int FRAME_LEN  = 2048,
  parameter int FIRST_SLOT = 2039,
  parameter int SW         = 3,
  localparam int CW        = $clog2(FRAME_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_i,
  output logic [CW-1:0] period_o,
  output logic [SW-1:0] rd_stream_o,
  output logic [CW-SW-1:0] rd_group_o,
  output logic          start_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] nxt;
  logic [CW-1:0] slot;

  assign period_o = frame_i ? '0 : cnt_q;
  assign nxt      = period_o + 1'b1;
  // look-ahead: slot index of the next period
  assign slot        = nxt + CW'(FRAME_LEN - FIRST_SLOT);
  assign rd_stream_o = slot[SW-1:0];
  assign rd_group_o  = slot[CW-1:SW];
  assign start_o     = (slot == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt;
  end
endmodule

// File: rtl/oecs_rate_latch.sv
module oecs_rate_latch
  import oecs_pkg::*;
#(
  parameter int NUM_STREAMS = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [RATE_W*NUM_STREAMS-1:0] rate_i,
  output logic [RATE_W*NUM_STREAMS-1:0] rate_o
);
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_rate
    logic [RATE_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     r_q <= RATE_2M;
      else if (load_i) r_q <= rate_i[s*RATE_W +: RATE_W];
    end
    assign rate_o[s*RATE_W +: RATE_W] = r_q;
  end
endmodule

// File: rtl/oecs_enable_mem.sv
module oecs_enable_mem #(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CH      = 256,
  localparam int SW         = $clog2(NUM_STREAMS),
  localparam int CHW        = $clog2(NUM_CH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [SW-1:0]  wr_stream_i,
  input  logic [CHW-1:0] wr_chan_i,
  input  logic           wr_bit_i,
  input  logic [SW-1:0]  rd_stream_i,
  input  logic [CHW-1:0] rd_chan_i,
  output logic           rd_bit_o
);
  logic [NUM_STREAMS-1:0] row_bit;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_row
    logic [NUM_CH-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) row_q <= '0;
      else if (we_i && wr_stream_i == SW'(s)) row_q[wr_chan_i] <= wr_bit_i;
    end
    assign row_bit[s] = row_q[rd_chan_i];
  end

  // read sees contents before a same-cycle write
  assign rd_bit_o = row_bit[rd_stream_i];
endmodule

// File: rtl/oe_ctrl_serializer.sv
module oe_ctrl_serializer
  import oecs_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int FRAME_LEN   = 2048,
  parameter int FIRST_SLOT  = 2039,
  localparam int SW         = $clog2(NUM_STREAMS),
  localparam int NUM_CH     = FRAME_LEN / NUM_STREAMS,
  localparam int CHW        = $clog2(NUM_CH),
  localparam int CW         = $clog2(FRAME_LEN)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          frame_i,
  input  logic [RATE_W*NUM_STREAMS-1:0] rate_i,
  input  logic                          wr_en_i,
  input  logic [SW-1:0]                 wr_stream_i,
  input  logic [CHW-1:0]                wr_chan_i,
  input  logic                          wr_bit_i,
  output logic                          ctrl_o
);
  logic [CW-1:0]                  period;
  logic [SW-1:0]                  rd_stream;
  logic [CHW-1:0]                 rd_group;
  logic [CHW-1:0]                 rd_chan;
  logic                           cf_start;
  logic [RATE_W*NUM_STREAMS-1:0]  rate_flat;
  logic [RATE_W-1:0]              rd_rate;
  logic                           rd_bit;
  logic                           ctrl_q;

  oecs_slot_timer #(
    .FRAME_LEN (FRAME_LEN),
    .FIRST_SLOT(FIRST_SLOT),
    .SW        (SW)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .period_o   (period),
    .rd_stream_o(rd_stream),
    .rd_group_o (rd_group),
    .start_o    (cf_start)
  );

  // rates change only where group 0 begins, so no channel is split
  oecs_rate_latch #(.NUM_STREAMS(NUM_STREAMS)) u_rate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cf_start),
    .rate_i(rate_i),
    .rate_o(rate_flat)
  );

  assign rd_rate = rate_flat[rd_stream*RATE_W +: RATE_W];
  assign rd_chan = rd_group >> (RATE_TOP - rd_rate);

  oecs_enable_mem #(
    .NUM_STREAMS(NUM_STREAMS),
    .NUM_CH     (NUM_CH)
  ) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_en_i),
    .wr_stream_i(wr_stream_i),
    .wr_chan_i  (wr_chan_i),
    .wr_bit_i   (wr_bit_i),
    .rd_stream_i(rd_stream),
    .rd_chan_i  (rd_chan),
    .rd_bit_o   (rd_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= 1'b0;
    else         ctrl_q <= rd_bit;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/oe_ctrl_serializer_chk.sv
module oe_ctrl_serializer_chk #(
  parameter int NUM_STREAMS = 8,
  parameter int FRAME_LEN   = 2048,
  localparam int SW         = $clog2(NUM_STREAMS),
  localparam int CW         = $clog2(FRAME_LEN)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        frame_i,
  input logic                        ctrl_o,
  input logic [CW-1:0]               period_i,
  input logic [SW-1:0]               rd_stream_i,
  input logic                        start_i,
  input logic [2*NUM_STREAMS-1:0]    rate_i
);
  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (ctrl_o == 1'b0);
    end
  end

  // R2
  period_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |-> period_i == CW'($past(period_i) + 1'b1));

  // R3
  stream_interleave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |-> rd_stream_i == SW'($past(rd_stream_i) + 1'b1));

  // R9
  rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(rate_i));
endmodule

bind oe_ctrl_serializer oe_ctrl_serializer_chk #(
  .NUM_STREAMS(NUM_STREAMS),
  .FRAME_LEN  (FRAME_LEN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_i    (frame_i),
  .ctrl_o     (ctrl_o),
  .period_i   (period),
  .rd_stream_i(rd_stream),
  .start_i    (cf_start),
  .rate_i     (rate_flat)
);

// File: tb/oe_ctrl_serializer_tb_top.sv
`timescale 1ns/1ps
module oe_ctrl_serializer_tb_top;
  localparam int NS    = 8;
  localparam int FL    = 2048;
  localparam int NCH   = FL / NS;
  localparam int FIRST = 2039;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frame = 1'b0;
  logic [2*NS-1:0] rate = '0;
  logic            we = 1'b0;
  logic [2:0]      wst = '0;
  logic [7:0]      wch = '0;
  logic            wbit = 1'b0;
  logic            ctrl;

  always #2.5 clk = ~clk;

  oe_ctrl_serializer dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .frame_i    (frame),
    .rate_i     (rate),
    .wr_en_i    (we),
    .wr_stream_i(wst),
    .wr_chan_i  (wch),
    .wr_bit_i   (wbit),
    .ctrl_o     (ctrl)
  );

  int errs = 0;
  int checks = 0;
  int tp = 0;
  bit mem_m [NS][NCH];
  int rate_eff [NS];
  int rate_snap [NS];
  int rate_req [NS];
  bit pend = 0;
  int pk = 0, pc = 0;
  bit pv = 0;
  string ph = "R8";

  function automatic int slot_k(int p);
    return ((p + FL - FIRST) % FL) % NS;
  endfunction

  function automatic int slot_ch(int p);
    int q = (p + FL - FIRST) % FL;
    return (q / NS) >> (3 - rate_eff[q % NS]);
  endfunction

  function automatic bit pat(int k, int c, int s);
    return ((k * 5 + c * 3 + s) % 7) < 3;
  endfunction

  task automatic check(input logic got, input logic exp, input string tag, input int p);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s period=%0d got=%b exp=%b", tag, p, got, exp);
    end
  endtask

  task automatic tick(input bit do_w, input int k, input int c, input bit v);
    string tag;
    int ek;
    @(negedge clk);
    if (tp == FIRST) for (int s = 0; s < NS; s++) rate_eff[s] = rate_snap[s];
    ek = slot_k(tp);
    if (tp == 0 || tp == FL - 1) tag = "R2";
    else if (tp >= FIRST && tp <= FIRST + 7) tag = "R3";
    else if (ph != "") tag = ph;
    else case (rate_eff[ek])
      3: tag = "R4";
      2: tag = "R5";
      1: tag = "R6";
      default: tag = "R7";
    endcase
    check(ctrl, mem_m[ek][slot_ch(tp)], tag, tp);
    if (pend) mem_m[pk][pc] = pv;
    pend = 0;
    rst_n = 1'b1;
    frame = (tp == 0);
    for (int s = 0; s < NS; s++) rate[2*s +: 2] = 2'(rate_req[s]);
    if (tp == FIRST - 1) for (int s = 0; s < NS; s++) rate_snap[s] = rate_req[s];
    we = do_w;
    wst = 3'(k);
    wch = 8'(c);
    wbit = v;
    if (do_w) begin
      pend = 1; pk = k; pc = c; pv = v;
    end
    tp = (tp + 1) % FL;
  endtask

  initial begin
    #(5.0 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      rate_eff[s] = 0; rate_snap[s] = 0; rate_req[s] = 0;
      for (int c = 0; c < NCH; c++) mem_m[s][c] = 0;
    end
    // R1: output quiet in reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(ctrl, 1'b0, "R1", -1);
    end
    // R8: fill the memory while running, all streams at 2.048 Mb/s
    ph = "R8";
    for (int i = 0; i < FL; i++) tick(1, i / NCH, i % NCH, pat(i / NCH, i % NCH, 1));
    // mixed rates, taken at the next control-frame start
    for (int s = 0; s < NS; s++) rate_req[s] = s % 4;
    for (int i = 0; i < FL; i++) tick(0, 0, 0, 0);
    ph = "";
    for (int i = 0; i < FL; i++) tick(0, 0, 0, 0);
    // R9: mid-frame rate change held off until period 2039
    ph = "R9";
    for (int i = 0; i < FL; i++) begin
      if (i == 1000) for (int s = 0; s < NS; s++) rate_req[s] = (s + 1) % 4;
      tick(0, 0, 0, 0);
    end
    // R10: write the entry being read in the same cycle
    ph = "R10";
    for (int i = 0; i < FL; i++) begin
      if (i >= 100 && i < 1500) begin
        int nt, nk, nc;
        nt = (tp + 1) % FL;
        nk = slot_k(nt);
        nc = slot_ch(nt);
        tick(1, nk, nc, !mem_m[nk][nc]);
      end else tick(0, 0, 0, 0);
    end
    // all streams at 16.384 Mb/s, then fresh contents
    ph = "";
    for (int s = 0; s < NS; s++) rate_req[s] = 3;
    for (int i = 0; i < FL; i++) tick(0, 0, 0, 0);
    for (int i = 0; i < FL; i++) tick(1, i % NS, i / NS, pat(i % NS, i / NS, 4));
    for (int i = 0; i < FL; i++) tick(0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule